// File: doc/BRIEF.md
# Outbound Region Address Translator

This block sits in the outbound request path of a PCIe-style root port. It steers each request address into a translated bus address and a transaction kind. Software programs up to eight regions through a small register window. Each region has a 64-bit base, an inclusive limit, a target, a kind code and an enable bit. For every request the block picks the lowest-numbered enabled region whose window holds the address. It returns `target + (address - base)` together with the kind one clock later. When no region holds the address, it raises a miss flag.

Configuration-kind regions carry a bus/device/function number in the target. For such hits the block also reports that number as a separate field. By default a region's upper limit half is ignored, so a window stays inside the 4 GB block of its base. A per-region wide bit lets the full 64-bit limit take part in the compare.

Top module: `obx_top`

## Requirements
- R1: After reset every region reads back as zero and is disabled, and a request returns `rsp_valid`=1 with `rsp_miss`=1.
- R2: Window address is {region[2:0], dir, offset[7:0]}; offsets 0x00 kind word (kind in bits [4:0], wide in bit 13), 0x04 enable word (enable in bit 31), 0x08/0x0C base low/high, 0x10 limit low, 0x20 limit high, 0x14/0x18 target low/high. A written enable bit reads back as 1 on the cycle after the write.
- R3: Writes with the dir bit (window bit 8) set are ignored and such addresses read as zero.
- R4: A request hits a region when base ≤ address ≤ limit (both ends inclusive), and `rsp_addr` = target + (address − base).
- R5: `rsp_type` returns the hitting region's kind code: 0 memory, 2 I/O, 4 configuration type 0, 5 configuration type 1; `rsp_region` gives its index.
- R6: When several enabled regions hold the address, the lowest index wins.
- R7: On a miss, `rsp_miss`=1, `rsp_addr` equals the request address and `rsp_type`=0.
- R8: With the wide bit clear the effective limit is {base[63:32], limit[31:0]}; with it set the full 64-bit limit is used.
- R9: For kind 4 or 5 hits, `rsp_bdf` = `rsp_addr[31:16]` (bus [31:24], device [23:19], function [18:16]); otherwise it is 0.
- R10: A disabled region never produces a hit.
- R11: A request in the same cycle as a register write is translated with the register contents from before that write.
- R12: `rsp_valid` is high exactly on the cycle after a cycle with `req_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register window address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from cfg_addr |
| req_valid | input | 1 | Request address valid |
| req_addr | input | 64 | Request address |
| rsp_valid | output | 1 | Translation result valid |
| rsp_addr | output | 64 | Translated or passed-through address |
| rsp_type | output | 5 | Transaction kind code |
| rsp_miss | output | 1 | No region matched |
| rsp_region | output | 3 | Index of the winning region |
| rsp_bdf | output | 16 | Bus/device/function for configuration hits |

## Verification
A register write and an address lookup can land on the same clock edge. Disabling a region while a request aimed at it is presented is the most likely case. The bench drives both in one cycle. It expects the request to be translated by the still-enabled region. It then expects the next request to the same address to miss and pass through unchanged.

// File: rtl/obx_pkg.sv
// Shared types and constants for the outbound region translator.
// Assumes 64-bit request addresses and a 32-bit register window.
package obx_pkg;
    localparam int ADDR_W = 64;

    localparam logic [4:0] KIND_MEM  = 5'd0;
    localparam logic [4:0] KIND_IO   = 5'd2;
    localparam logic [4:0] KIND_CFG0 = 5'd4;
    localparam logic [4:0] KIND_CFG1 = 5'd5;

    localparam logic [7:0] OFS_KIND  = 8'h00;
    localparam logic [7:0] OFS_ENAB  = 8'h04;
    localparam logic [7:0] OFS_BASEL = 8'h08;
    localparam logic [7:0] OFS_BASEH = 8'h0C;
    localparam logic [7:0] OFS_LIML  = 8'h10;
    localparam logic [7:0] OFS_TGTL  = 8'h14;
    localparam logic [7:0] OFS_TGTH  = 8'h18;
    localparam logic [7:0] OFS_LIMH  = 8'h20;

    localparam int WIDE_BIT = 13;
    localparam int EN_BIT   = 31;

    typedef struct packed {
        logic              en;
        logic              wide;
        logic [4:0]        kind;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
        logic [ADDR_W-1:0] target;
    } region_t;
endpackage

// File: rtl/obx_regs.sv
// Region register file behind the programming window.
// Window address = {region index, dir bit, byte offset}; dir=1 slots are
// not implemented (writes dropped, reads zero). Full-word writes only.
module obx_regs
    import obx_pkg::*;
#(
    parameter int NREG = 8,
    localparam int RI_W  = $clog2(NREG),
    localparam int WIN_W = RI_W + 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIN_W-1:0] addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    output region_t          regs_o [NREG]
);
    logic            dir_in;
    logic [RI_W-1:0] rsel;
    logic [7:0]      ofs;
    logic            slot_ok;

    // Split the window address into its fields.
    always_comb begin
        dir_in  = addr[8];
        rsel    = addr[WIN_W-1:9];
        ofs     = addr[7:0];
        slot_ok = !dir_in && (int'(rsel) < NREG);
    end

    // Register writes, one field per offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_o[i] <= '0;
        end else if (wr_en && slot_ok) begin
            case (ofs)
                OFS_KIND: begin
                    regs_o[rsel].kind <= wdata[4:0];
                    regs_o[rsel].wide <= wdata[WIDE_BIT];
                end
                OFS_ENAB:  regs_o[rsel].en            <= wdata[EN_BIT];
                OFS_BASEL: regs_o[rsel].base[31:0]    <= wdata;
                OFS_BASEH: regs_o[rsel].base[63:32]   <= wdata;
                OFS_LIML:  regs_o[rsel].limit[31:0]   <= wdata;
                OFS_LIMH:  regs_o[rsel].limit[63:32]  <= wdata;
                OFS_TGTL:  regs_o[rsel].target[31:0]  <= wdata;
                OFS_TGTH:  regs_o[rsel].target[63:32] <= wdata;
                default: ;
            endcase
        end
    end

    // Combinational read-back of the addressed field.
    always_comb begin
        rdata = '0;
        if (slot_ok) begin
            case (ofs)
                OFS_KIND:  rdata = {18'd0, regs_o[rsel].wide, 8'd0, regs_o[rsel].kind};
                OFS_ENAB:  rdata = {regs_o[rsel].en, 31'd0};
                OFS_BASEL: rdata = regs_o[rsel].base[31:0];
                OFS_BASEH: rdata = regs_o[rsel].base[63:32];
                OFS_LIML:  rdata = regs_o[rsel].limit[31:0];
                OFS_LIMH:  rdata = regs_o[rsel].limit[63:32];
                OFS_TGTL:  rdata = regs_o[rsel].target[31:0];
                OFS_TGTH:  rdata = regs_o[rsel].target[63:32];
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/obx_match.sv
// Per-region window compare and address translation, one copy per region.
// Assumes limit >= base for every enabled region.
module obx_match
    import obx_pkg::*;
#(
    parameter int NREG = 8
) (
    input  region_t           regs [NREG],
    input  logic [ADDR_W-1:0] addr,
    output logic [NREG-1:0]   hit,
    output logic [ADDR_W-1:0] xl   [NREG],
    output logic [4:0]        kind [NREG]
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [ADDR_W-1:0] eff_lim;
        // Upper limit half only counts when the wide bit is set.
        always_comb begin
            eff_lim = regs[g].wide ? regs[g].limit
                                   : {regs[g].base[63:32], regs[g].limit[31:0]};
            hit[g]  = regs[g].en && (addr >= regs[g].base) && (addr <= eff_lim);
            xl[g]   = regs[g].target + (addr - regs[g].base);
            kind[g] = regs[g].kind;
        end
    end
endmodule

// File: rtl/obx_pick.sv
// Lowest-index priority select and result register.
// One clock from request to response; miss passes the address through.
module obx_pick
    import obx_pkg::*;
#(
    parameter int NREG = 8,
    localparam int RI_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [NREG-1:0]   hit,
    input  logic [ADDR_W-1:0] xl   [NREG],
    input  logic [4:0]        kind [NREG],
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [4:0]        rsp_type,
    output logic              rsp_miss,
    output logic [RI_W-1:0]   rsp_region,
    output logic [15:0]       rsp_bdf
);
    logic [RI_W-1:0]   win;
    logic [ADDR_W-1:0] n_addr;
    logic [4:0]        n_kind;
    logic [15:0]       n_bdf;

    // Scan from the top down so the lowest hitting index is kept.
    always_comb begin
        win = '0;
        for (int i = NREG - 1; i >= 0; i--)
            if (hit[i]) win = RI_W'(i);
        if (|hit) begin
            n_addr = xl[win];
            n_kind = kind[win];
        end else begin
            n_addr = req_addr;
            n_kind = KIND_MEM;
        end
        n_bdf = (|hit && (n_kind == KIND_CFG0 || n_kind == KIND_CFG1))
                ? n_addr[31:16] : 16'd0;
    end

    // Result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_addr   <= '0;
            rsp_type   <= '0;
            rsp_miss   <= 1'b0;
            rsp_region <= '0;
            rsp_bdf    <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_addr   <= n_addr;
                rsp_type   <= n_kind;
                rsp_miss   <= ~|hit;
                rsp_region <= win;
                rsp_bdf    <= n_bdf;
            end
        end
    end
endmodule

// File: rtl/obx_top.sv
// Outbound region address translator: register window, per-region
// compare, priority select. Requests use pre-edge register contents.
module obx_top
    import obx_pkg::*;
#(
    parameter int NREG = 8,
    localparam int RI_W  = $clog2(NREG),
    localparam int WIN_W = RI_W + 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [WIN_W-1:0]  cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [4:0]        rsp_type,
    output logic              rsp_miss,
    output logic [RI_W-1:0]   rsp_region,
    output logic [15:0]       rsp_bdf
);
    region_t           regs [NREG];
    logic [NREG-1:0]   hit;
    logic [ADDR_W-1:0] xl   [NREG];
    logic [4:0]        kind [NREG];
    logic [NREG-1:0]   en_vec;

    for (genvar g = 0; g < NREG; g++) begin : g_en
        assign en_vec[g] = regs[g].en;
    end

    obx_regs #(.NREG(NREG)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .regs_o(regs)
    );

    obx_match #(.NREG(NREG)) u_match (
        .regs(regs), .addr(req_addr), .hit(hit), .xl(xl), .kind(kind)
    );

    obx_pick #(.NREG(NREG)) u_pick (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .hit(hit), .xl(xl), .kind(kind), .rsp_valid(rsp_valid),
        .rsp_addr(rsp_addr), .rsp_type(rsp_type), .rsp_miss(rsp_miss),
        .rsp_region(rsp_region), .rsp_bdf(rsp_bdf)
    );
endmodule

// File: rtl/obx_chk.sv
// Property checker for obx_top, attached by bind below.
module obx_chk #(
    parameter int NREG = 8,
    localparam int WIN_W = $clog2(NREG) + 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr_en,
    input logic [WIN_W-1:0] cfg_addr,
    input logic             req_valid,
    input logic [63:0]      req_addr,
    input logic             rsp_valid,
    input logic             rsp_miss,
    input logic [63:0]      rsp_addr,
    input logic [4:0]       rsp_type,
    input logic [NREG-1:0]  en_vec
);
    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);                                     // R12
    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);                                   // R12
    AST_ALL_OFF_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && en_vec == '0) |=> rsp_miss);                    // R10
    AST_MISS_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_miss) |-> (rsp_addr == $past(req_addr) && rsp_type == 5'd0)); // R7
    AST_DIR_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_addr[8]) |=> $stable(en_vec));              // R3
endmodule

bind obx_top obx_chk #(.NREG(NREG)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .req_valid(req_valid), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_miss(rsp_miss), .rsp_addr(rsp_addr), .rsp_type(rsp_type),
    .en_vec(en_vec)
);

// File: tb/tb_obx_top.sv
// Directed bench for obx_top: one task per scenario.
module tb_obx_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic        rsp_valid;
    logic [63:0] rsp_addr;
    logic [4:0]  rsp_type;
    logic        rsp_miss;
    logic [2:0]  rsp_region;
    logic [15:0] rsp_bdf;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    obx_top dut (.*);

    function automatic logic [11:0] wa(input int r, input logic [7:0] o);
        return {r[2:0], 1'b0, o};
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #2 d = cfg_rdata;
    endtask

    task automatic prog(input int r, input logic [4:0] k, input logic wide,
                        input logic [63:0] b, input logic [63:0] l, input logic [63:0] t);
        logic [31:0] d;
        wr(wa(r, 8'h04), 32'h0);
        wr(wa(r, 8'h08), b[31:0]);  wr(wa(r, 8'h0C), b[63:32]);
        wr(wa(r, 8'h10), l[31:0]);  wr(wa(r, 8'h20), l[63:32]);
        wr(wa(r, 8'h14), t[31:0]);  wr(wa(r, 8'h18), t[63:32]);
        wr(wa(r, 8'h00), {18'd0, wide, 8'd0, k});
        wr(wa(r, 8'h04), 32'h8000_0000);
        rd(wa(r, 8'h04), d);
        check("R2 enable reads back", 64'(d[31]), 64'd1);
        rd(wa(r, 8'h00), d);
        check("R2 kind word readback", 64'(d), 64'({18'd0, wide, 8'd0, k}));
    endtask

    // Present one request and sample the registered result.
    task automatic look(input logic [63:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check("R12 rsp_valid after req", 64'(rsp_valid), 64'd1);
    endtask

    task automatic expect_hit(input string tag, input logic [63:0] a, input logic [63:0] x,
                              input logic [4:0] k, input int r);
        look(a);
        check({tag, " miss"}, 64'(rsp_miss), 64'd0);
        check({tag, " addr"}, rsp_addr, x);
        check({tag, " type"}, 64'(rsp_type), 64'(k));
        check({tag, " region"}, 64'(rsp_region), 64'(r));
    endtask

    task automatic expect_miss(input string tag, input logic [63:0] a);
        look(a);
        check({tag, " miss"}, 64'(rsp_miss), 64'd1);
        check({tag, " addr"}, rsp_addr, a);
        check({tag, " type"}, 64'(rsp_type), 64'd0);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        rd(wa(0, 8'h04), d);   check("R1 enable clear", 64'(d), 64'd0);
        rd(wa(7, 8'h08), d);   check("R1 base clear", 64'(d), 64'd0);
        expect_miss("R1 R7 lookup after reset", 64'h0000_0000_0000_1000);
        @(negedge clk);
        check("R12 no rsp when idle", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_basic;
        prog(2, 5'd0, 1'b0, 64'h1000_0000, 64'h1000_FFFF, 64'h8_0000_0000);
        expect_hit("R4 base", 64'h1000_0000, 64'h8_0000_0000, 5'd0, 2);
        expect_hit("R4 limit inclusive", 64'h1000_FFFF, 64'h8_0000_FFFF, 5'd0, 2);
        expect_miss("R4 above limit", 64'h1001_0000);
        expect_miss("R4 below base", 64'h0FFF_FFFF);
    endtask

    task automatic t_kinds;
        prog(1, 5'd2, 1'b0, 64'h2000_0000, 64'h2000_00FF, 64'h3000_0000);
        expect_hit("R5 io", 64'h2000_0040, 64'h3000_0040, 5'd2, 1);
        check("R9 bdf zero for io", 64'(rsp_bdf), 64'd0);
    endtask

    task automatic t_cfg;
        prog(3, 5'd4, 1'b0, 64'h4000_0000, 64'h4000_FFFF, 64'h0519_0000);
        expect_hit("R5 R9 cfg0", 64'h4000_0010, 64'h0519_0010, 5'd4, 3);
        check("R9 cfg0 bdf", 64'(rsp_bdf), 64'h0519);
        prog(5, 5'd5, 1'b0, 64'h5000_0000, 64'h5000_FFFF, 64'h8000_0000);
        expect_hit("R5 R9 cfg1", 64'h5000_0004, 64'h8000_0004, 5'd5, 5);
        check("R9 cfg1 bdf", 64'(rsp_bdf), 64'h8000);
    endtask

    task automatic t_prio;
        prog(4, 5'd0, 1'b0, 64'h1000_0000, 64'h1000_00FF, 64'h0000_A000);
        expect_hit("R6 lowest index wins", 64'h1000_0010, 64'h8_0000_0010, 5'd0, 2);
        wr(wa(2, 8'h04), 32'h0);
        expect_hit("R10 disabled region skipped", 64'h1000_0010, 64'h0000_A010, 5'd0, 4);
    endtask

    task automatic t_wide;
        prog(6, 5'd0, 1'b0, 64'h1_0000_0000, 64'h2_0000_0FFF, 64'h7_0000_0000);
        expect_hit("R8 narrow in window", 64'h1_0000_0800, 64'h7_0000_0800, 5'd0, 6);
        expect_miss("R8 narrow ignores upper limit", 64'h2_0000_0800);
        wr(wa(6, 8'h00), 32'h0000_2000);
        expect_hit("R8 wide full limit", 64'h2_0000_0800, 64'h8_0000_0800, 5'd0, 6);
    endtask

    task automatic t_dir;
        logic [31:0] d;
        wr({3'd0, 1'b1, 8'h04}, 32'h8000_0000);
        wr({3'd0, 1'b1, 8'h08}, 32'h9000_0000);
        rd({3'd0, 1'b1, 8'h04}, d);  check("R3 dir slot reads zero", 64'(d), 64'd0);
        rd(wa(0, 8'h04), d);         check("R3 outbound slot untouched", 64'(d), 64'd0);
        expect_miss("R3 no region from dir write", 64'h9000_0000);
    endtask

    task automatic t_same;
        @(negedge clk);
        req_valid = 1'b1; req_addr = 64'h4000_0010;
        cfg_wr_en = 1'b1; cfg_addr = wa(3, 8'h04); cfg_wdata = 32'h0;
        @(negedge clk);
        req_valid = 1'b0; cfg_wr_en = 1'b0;
        check("R11 same-cycle uses old state", 64'(rsp_miss), 64'd0);
        check("R11 same-cycle addr", rsp_addr, 64'h0519_0010);
        expect_miss("R11 R10 after disable", 64'h4000_0010);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset;
        t_basic;
        t_kinds;
        t_cfg;
        t_prio;
        t_wide;
        t_dir;
        t_same;
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule